// File: doc/BRIEF.md
# Dual Masked Time-of-Day Alarm Comparator

This block watches a set of BCD calendar fields and compares them against two separate alarm register sets. The fields are seconds, minutes, hours, date, month, day of week and a century byte. Each alarm byte holds a compare value in its lower seven bits and an enable in its top bit. Only the enabled bytes of an alarm take part in the match. Year has no alarm byte.

A match is sampled only on cycles where the one-cycle tick strobe is high. The tick normally comes from the time-keeping logic once per second. Because of this, a match that lasts a whole second is seen only once.

Each alarm that matches sets its own sticky status flag. The flag stays set until a per-alarm clear strobe removes it. The active-low interrupt output works in one of two modes:
- **Level mode:** the output is held low while any flag with its interrupt enable set is pending.
- **Pulsed mode:** the output gives a fixed-width low pulse each time an enabled alarm matches.

The interrupt output is silent whenever the shared pin is set to carry a frequency instead.

Top module: `alarm_match_unit`

## Requirements
- R1: The alarm bus holds byte k of alarm a at bits [8*(7a+k)+7 : 8*(7a+k)]. The time bus holds byte k at bits [8k+7 : 8k]. The byte order for k = 0..6 is seconds, minutes, hours, date, month, day of week, century. In an alarm byte, bit 7 is the enable and bits 6:0 are the compare value. In a time byte, bit 7 is ignored.
- R2: An alarm matches when every enabled byte has bits 6:0 equal to the same bits of the time byte. Disabled bytes have no effect on the match.
- R3: An alarm with all seven enable bits at 0 never sets its flag.
- R4: Matches are evaluated only in cycles with `tick` high. A match with `tick` low changes no flag.
- R5: A match on a tick sets `alarmFlag[a]` at that clock edge. The flag holds until `statusClr[a]` is sampled high. If a new match and a clear arrive in the same cycle, the flag stays set.
- R6: The two alarms are independent. Each alarm sets only its own flag bit (bit 0 for alarm 0, bit 1 for alarm 1).
- R7: With `pulseMode`=0 and `freqSel`=00, `irqN` is 0 while any pending flag has its `irqEnable` bit set. Otherwise `irqN` is 1.
- R8: With `freqSel` not equal to 00, `irqN` stays 1 whatever the flags are.
- R9: With `pulseMode`=1 and `freqSel`=00, each tick on which an interrupt-enabled alarm matches drives `irqN` low for exactly PULSE_CYCLES cycles, starting at the clock edge of that tick. This happens again on every later match, even while the flag is still pending.
- R10: A flag is set by its match whether or not its `irqEnable` bit is set. With the enable at 0, `irqN` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle evaluation strobe |
| timeFields | input | 56 | Current time bytes, seven packed fields |
| alarmRegs | input | 112 | Two alarm sets of seven bytes with enable in bit 7 |
| irqEnable | input | 2 | Interrupt enable per alarm |
| pulseMode | input | 1 | 1 = pulsed interrupt, 0 = level-held |
| freqSel | input | 2 | Pin function select; 00 gives the pin to alarms |
| statusClr | input | 2 | Clear strobe per alarm flag |
| alarmFlag | output | 2 | Sticky match flags |
| irqN | output | 1 | Interrupt, active low |

## Verification
The hardest case to reach is a clear strobe that lands in the same cycle as a fresh matching tick. The bench gets there by keeping a full seven-field match in place after a flag is already set. It then raises `statusClr` and `tick` on the same falling edge and looks for the flag to survive.

A second hard case is re-firing in pulsed mode while the flag is still pending. The bench leaves the flag uncleared after a pulse has ended and ticks again. It then expects a new low pulse.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
  localparam int ALARM_COUNT = 2;
  localparam int FIELD_COUNT = 7;
  localparam int FIELD_BITS  = 8;
  localparam int VALUE_BITS  = FIELD_BITS - 1;
  localparam int TIME_W      = FIELD_COUNT * FIELD_BITS;
  localparam int ALARM_W     = ALARM_COUNT * TIME_W;

  typedef struct packed {
    logic [ALARM_COUNT-1:0] setFlag;
    logic [ALARM_COUNT-1:0] clrFlag;
  } ctrlStrobes_t;
endpackage

// File: rtl/alarm_cmp_datapath.sv
module alarm_cmp_datapath
  import alarm_cmp_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [TIME_W-1:0]      timeFields,
  input  logic [ALARM_W-1:0]     alarmRegs,
  input  ctrlStrobes_t           strobes,
  output logic [ALARM_COUNT-1:0] matchVec,
  output logic [ALARM_COUNT-1:0] flags
);
  logic [ALARM_COUNT-1:0][FIELD_COUNT-1:0] fieldEn;
  logic [ALARM_COUNT-1:0][FIELD_COUNT-1:0] fieldOk;

  for (genvar a = 0; a < ALARM_COUNT; a++) begin : gAlarm
    for (genvar f = 0; f < FIELD_COUNT; f++) begin : gField
      localparam int BASE = (a * FIELD_COUNT + f) * FIELD_BITS;
      logic fieldEq;
      assign fieldEn[a][f] = alarmRegs[BASE + FIELD_BITS - 1];
      assign fieldEq = alarmRegs[BASE +: VALUE_BITS]
                       == timeFields[f*FIELD_BITS +: VALUE_BITS];
      assign fieldOk[a][f] = !fieldEn[a][f] || fieldEq;
    end

    // An alarm with nothing enabled must not match
    assign matchVec[a] = (|fieldEn[a]) && (&fieldOk[a]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                    flags[a] <= 1'b0;
      else if (strobes.setFlag[a])  flags[a] <= 1'b1;
      else if (strobes.clrFlag[a])  flags[a] <= 1'b0;
    end

    assert_set_sticks_R5: assert property (@(posedge clk) disable iff (!rstN)
      strobes.setFlag[a] |=> flags[a]);
    assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.clrFlag[a] && !strobes.setFlag[a]) |=> !flags[a]);
    assert_empty_never_fires_R3: assert property (@(posedge clk) disable iff (!rstN)
      (fieldEn[a] == '0 && !flags[a]) |=> !flags[a]);
  end
endmodule

// File: rtl/alarm_cmp_control.sv
module alarm_cmp_control
  import alarm_cmp_pkg::*;
#(
  parameter int PULSE_CYCLES = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tick,
  input  logic [ALARM_COUNT-1:0] matchVec,
  input  logic [ALARM_COUNT-1:0] flags,
  input  logic [ALARM_COUNT-1:0] statusClr,
  input  logic [ALARM_COUNT-1:0] irqEnable,
  input  logic                   pulseMode,
  input  logic [1:0]             freqSel,
  output ctrlStrobes_t           strobes,
  output logic                   irqN
);
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);

  logic [CNT_W-1:0] pulseCnt;
  logic             pulseLoad;
  logic             pinForAlarm;

  assign strobes.setFlag = {ALARM_COUNT{tick}} & matchVec;
  assign strobes.clrFlag = statusClr;
  assign pulseLoad       = pulseMode && (|(strobes.setFlag & irqEnable));
  assign pinForAlarm     = (freqSel == 2'b00);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pulseCnt <= '0;
    else if (pulseLoad)     pulseCnt <= CNT_W'(PULSE_CYCLES);
    else if (pulseCnt != 0) pulseCnt <= pulseCnt - 1'b1;
  end

  always_comb begin
    irqN = 1'b1;
    if (pinForAlarm) begin
      if (pulseMode) irqN = (pulseCnt == '0);
      else           irqN = !(|(flags & irqEnable));
    end
  end

  for (genvar a = 0; a < ALARM_COUNT; a++) begin : gChk
    assert_tick_gated_R4: assert property (@(posedge clk) disable iff (!rstN)
      (!tick && !flags[a]) |=> !flags[a]);
  end

  assert_pulse_starts_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pulseLoad && pinForAlarm && pulseMode) ##1 (pinForAlarm && pulseMode) |-> !irqN);
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
  import alarm_cmp_pkg::*;
#(
  parameter int PULSE_CYCLES = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tick,
  input  logic [TIME_W-1:0]      timeFields,
  input  logic [ALARM_W-1:0]     alarmRegs,
  input  logic [ALARM_COUNT-1:0] irqEnable,
  input  logic                   pulseMode,
  input  logic [1:0]             freqSel,
  input  logic [ALARM_COUNT-1:0] statusClr,
  output logic [ALARM_COUNT-1:0] alarmFlag,
  output logic                   irqN
);
  ctrlStrobes_t           strobes;
  logic [ALARM_COUNT-1:0] matchVec;

  alarm_cmp_datapath u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .timeFields (timeFields),
    .alarmRegs  (alarmRegs),
    .strobes    (strobes),
    .matchVec   (matchVec),
    .flags      (alarmFlag)
  );

  alarm_cmp_control #(.PULSE_CYCLES(PULSE_CYCLES)) u_control (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .matchVec  (matchVec),
    .flags     (alarmFlag),
    .statusClr (statusClr),
    .irqEnable (irqEnable),
    .pulseMode (pulseMode),
    .freqSel   (freqSel),
    .strobes   (strobes),
    .irqN      (irqN)
  );
endmodule

// File: tb/alarm_match_unit_bench.sv
module alarm_match_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         tick = 1'b0;
  logic [55:0]  timeFields;
  logic [111:0] alarmRegs;
  logic [1:0]   irqEnable = 2'b00;
  logic         pulseMode = 1'b0;
  logic [1:0]   freqSel = 2'b00;
  logic [1:0]   statusClr = 2'b00;
  logic [1:0]   alarmFlag;
  logic         irqN;

  logic [7:0] tf [7];
  logic [7:0] ar [2][7];

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < 7; i++) begin
      timeFields[i*8 +: 8] = tf[i];
      alarmRegs[i*8 +: 8] = ar[0][i];
      alarmRegs[(7+i)*8 +: 8] = ar[1][i];
    end
  end

  alarm_match_unit #(.PULSE_CYCLES(PULSE)) u_alarm_match_unit (
    .clk(clk), .rstN(rstN), .tick(tick), .timeFields(timeFields),
    .alarmRegs(alarmRegs), .irqEnable(irqEnable), .pulseMode(pulseMode),
    .freqSel(freqSel), .statusClr(statusClr), .alarmFlag(alarmFlag), .irqN(irqN)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doTick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic clearFlags();
    @(negedge clk) statusClr = 2'b11;
    @(negedge clk) statusClr = 2'b00;
  endtask

  task automatic wipeRegs();
    for (int a = 0; a < 2; a++)
      for (int i = 0; i < 7; i++) ar[a][i] = 8'h00;
  endtask

  task automatic testReset();
    check("R5 reset flags", 32'(alarmFlag), 32'h0);
    check("R7 reset irqN", 32'(irqN), 32'h1);
  endtask

  task automatic testSingleField();
    wipeRegs();
    ar[0][0] = 8'hB0;            // seconds 30 enabled
    irqEnable = 2'b01;
    doTick();
    check("R2 single field match flag", 32'(alarmFlag), 32'h1);
    check("R7 level irq asserted", 32'(irqN), 32'h0);
    clearFlags();
    check("R5 clear drops flag", 32'(alarmFlag), 32'h0);
    check("R7 level irq released", 32'(irqN), 32'h1);
  endtask

  task automatic testMismatch();
    ar[0][1] = 8'hC5;            // minutes 45 enabled, time is 44
    doTick();
    check("R2 one enabled field differs", 32'(alarmFlag), 32'h0);
  endtask

  task automatic testIgnoredBits();
    // alarm1: hours 07 enabled, minutes disabled with other value; time hour MSB set
    ar[1][2] = 8'h87;
    ar[1][1] = 8'h12;
    doTick();
    check("R1 R6 alarm1 only, MSB and disabled byte ignored", 32'(alarmFlag), 32'h2);
    clearFlags();
  endtask

  task automatic testNoEnable();
    wipeRegs();
    for (int i = 0; i < 7; i++) ar[0][i] = tf[i] & 8'h7F;
    irqEnable = 2'b11;
    doTick();
    check("R3 no enabled byte no flag", 32'(alarmFlag), 32'h0);
    check("R3 no enabled byte no irq", 32'(irqN), 32'h1);
  endtask

  task automatic testTickGating();
    for (int i = 0; i < 7; i++) ar[0][i] = tf[i] | 8'h80;
    irqEnable = 2'b01;
    repeat (5) @(negedge clk);
    check("R4 match without tick", 32'(alarmFlag), 32'h0);
    doTick();
    check("R2 all seven fields match", 32'(alarmFlag), 32'h1);
  endtask

  task automatic testSetBeatsClear();
    @(negedge clk) begin statusClr = 2'b01; tick = 1'b1; end
    @(negedge clk) begin statusClr = 2'b00; tick = 1'b0; end
    check("R5 set wins over clear", 32'(alarmFlag), 32'h1);
    clearFlags();
    check("R5 clear alone", 32'(alarmFlag), 32'h0);
  endtask

  task automatic testFreqSel();
    freqSel = 2'b10;
    doTick();
    check("R8 flag still set", 32'(alarmFlag), 32'h1);
    check("R8 irq muted by freqSel", 32'(irqN), 32'h1);
    @(negedge clk) freqSel = 2'b00;
    #1 check("R7 irq back when freqSel 00", 32'(irqN), 32'h0);
    clearFlags();
  endtask

  task automatic testIrqDisabled();
    irqEnable = 2'b00;
    doTick();
    check("R10 flag without irq enable", 32'(alarmFlag), 32'h1);
    check("R10 irq stays high", 32'(irqN), 32'h1);
    clearFlags();
  endtask

  task automatic testPulse();
    irqEnable = 2'b01;
    pulseMode = 1'b1;
    doTick();
    check("R9 pulse begins", 32'(irqN), 32'h0);
    repeat (PULSE-1) @(negedge clk);
    check("R9 pulse still low at last cycle", 32'(irqN), 32'h0);
    @(negedge clk);
    check("R9 pulse ends", 32'(irqN), 32'h1);
    check("R9 flag remains pending", 32'(alarmFlag), 32'h1);
    doTick();
    check("R9 refire while pending", 32'(irqN), 32'h0);
    repeat (PULSE) @(negedge clk);
    check("R9 second pulse ends", 32'(irqN), 32'h1);
    pulseMode = 1'b0;
    clearFlags();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wipeRegs();
    tf[0] = 8'h30; tf[1] = 8'h44; tf[2] = 8'h87; tf[3] = 8'h15;
    tf[4] = 8'h06; tf[5] = 8'h03; tf[6] = 8'h20;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testSingleField();
    testMismatch();
    testIgnoredBits();
    testNoEnable();
    testTickGating();
    testSetBeatsClear();
    testFreqSel();
    testIrqDisabled();
    testPulse();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule